// File: doc/BRIEF.md
# Single-Precision Floating-Point Add/Subtract Unit

This unit adds or subtracts two binary floating-point words and returns a rounded word of the same format, with two range flags. Its default format is the 32-bit single-precision layout. Bit 31 holds the sign. Bits 30..23 hold an exponent biased by 127, and bits 22..0 hold the fraction. A normal word is worth (-1)^S × (1+F) × 2^(E−127). The format widths are parameters, so the same RTL also builds a narrow format that can be swept exhaustively.

The datapath works in a fixed order. Special encodings are resolved first. A zero operand then short-circuits the rest. Otherwise the significand of the smaller operand is aligned with guard, round and sticky bits, and the magnitudes are added or subtracted. The result is normalised, rounded to nearest-even and range-checked. Subnormal operands count as zero, and subnormal results are flushed to zero.

The result is registered once. Operands applied before a rising clock edge appear at the outputs after that edge.

Top module: `fp_addsub`

## Requirements
- R1: For two normal operands (exponent field neither all zeros nor all ones), res is the exact sum rounded to nearest-even, in the layout {sign, biased exponent, fraction} with the hidden leading 1 restored before the arithmetic. ovf and unf stay low when the result is in range.
- R2: When sub_sel is 1, the sign of op_b is inverted before any other step, so the result is op_a − op_b.
- R3: An operand whose exponent field is 0 is zero, whatever its fraction. If op_a is zero and op_b is not, res is op_b with the R2 sign applied. If op_b is zero and op_a is not, res is op_a unchanged. If both are zero, res is a zero carrying the R2 sign of op_b, with its fraction cleared.
- R4: The significand with the smaller magnitude is shifted right by the exponent difference. The shift saturates at FRAC_W+3, and every bit shifted out is ORed into a sticky bit that takes part in rounding.
- R5: After a subtraction that cancels leading bits, the result is shifted left until its leading 1 is in the hidden position, and the exponent is reduced by the shift. For example, 0.5 − 0.4375 gives 0.0625 (0x3F000000 − 0x3EE00000 = 0x3D800000).
- R6: Rounding is to nearest with ties to even. If the increment carries out of the significand, the result is renormalised and the exponent is incremented.
- R7: If the rounded biased exponent exceeds 2^EXP_W−2 (254), res is a signed infinity (exponent all ones, fraction 0) and ovf is 1. ovf and unf are never 1 together.
- R8: If the rounded biased exponent is below 1, res is a zero carrying the sign of the true result and unf is 1.
- R9: A sum that is exactly zero returns +0 (all bits 0) with both flags low.
- R10: An operand whose exponent field is all ones counts as an infinity of its sign, whatever its fraction. With one such operand, or two of the same sign, res is a canonical infinity (fraction 0) of that sign, with both flags low.
- R11: Two infinity-class operands of opposite effective sign return the quiet NaN 0x7FC00000: sign 0, exponent all ones, fraction MSB 1 and the other fraction bits 0.
- R12: While rst_n is low, res, ovf and unf are 0. Otherwise the outputs change only at a rising clk edge and show the operands present just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | EXP_W+FRAC_W+1 | First operand |
| op_b | input | EXP_W+FRAC_W+1 | Second operand |
| sub_sel | input | 1 | 1 selects op_a − op_b, 0 selects op_a + op_b |
| res | output | EXP_W+FRAC_W+1 | Registered result word |
| ovf | output | 1 | Result exponent overflowed, res is infinity |
| unf | output | 1 | Result exponent underflowed, res is zero |

## Verification
The hardest cases to reach are exact rounding ties and round-up carries that ripple into the exponent. These need operand pairs whose low bits line up precisely, and so are rare among arbitrary single-precision words. The bench therefore builds the same RTL in a 3-bit exponent, 3-bit fraction format and applies every operand pair under both operations. Each result is compared with an exact integer model: both operands are scaled to a common unit, summed exactly and rounded by remainder comparison. A directed single-precision list covers the saturated shift, sticky-only round-up, the tie and carry cases, and both range limits.

// File: rtl/fp_pkg.sv
`timescale 1ns/1ps
package fp_pkg;
    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NORM = 2'd1,
        CLS_INF  = 2'd2
    } fp_cls_e;
endpackage

// File: rtl/fp_unpack.sv
`timescale 1ns/1ps
module fp_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word_i,
    input  logic                  flip_i,
    output logic                  sign_o,
    output logic [EXP_W-1:0]      exp_o,
    output logic [FRAC_W:0]       sig_o,
    output fp_pkg::fp_cls_e       cls_o
);
    localparam int MSB = EXP_W + FRAC_W;

    always_comb begin
        sign_o = word_i[MSB] ^ flip_i;
        exp_o  = word_i[FRAC_W +: EXP_W];
        sig_o  = {1'b1, word_i[FRAC_W-1:0]};
        if (exp_o == '0)
            cls_o = fp_pkg::CLS_ZERO;
        else if (exp_o == '1)
            cls_o = fp_pkg::CLS_INF;
        else
            cls_o = fp_pkg::CLS_NORM;
    end
endmodule

// File: rtl/fp_align.sv
`timescale 1ns/1ps
module fp_align #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  sign_a_i,
    input  logic [EXP_W-1:0]      exp_a_i,
    input  logic [FRAC_W:0]       sig_a_i,
    input  logic                  sign_b_i,
    input  logic [EXP_W-1:0]      exp_b_i,
    input  logic [FRAC_W:0]       sig_b_i,
    output logic                  big_sign_o,
    output logic                  small_sign_o,
    output logic [EXP_W-1:0]      big_exp_o,
    output logic [FRAC_W+3:0]     big_ext_o,
    output logic [FRAC_W+3:0]     small_ext_o
);
    localparam int XW  = FRAC_W + 4;
    localparam int SAT = FRAC_W + 3;

    logic              swap;
    logic [EXP_W-1:0]  small_exp;
    logic [FRAC_W:0]   big_sig, small_sig;
    logic [31:0]       diff, shamt;
    logic [2*XW-1:0]   wide;

    always_comb begin
        swap         = {exp_b_i, sig_b_i} > {exp_a_i, sig_a_i};
        big_sign_o   = swap ? sign_b_i : sign_a_i;
        small_sign_o = swap ? sign_a_i : sign_b_i;
        big_exp_o    = swap ? exp_b_i  : exp_a_i;
        small_exp    = swap ? exp_a_i  : exp_b_i;
        big_sig      = swap ? sig_b_i  : sig_a_i;
        small_sig    = swap ? sig_a_i  : sig_b_i;
        diff         = 32'(big_exp_o) - 32'(small_exp);
        shamt        = (diff > 32'(SAT)) ? 32'(SAT) : diff;
        wide         = {small_sig, 3'b000, {XW{1'b0}}} >> shamt;
        big_ext_o    = {big_sig, 3'b000};
        small_ext_o  = {wide[2*XW-1:XW+1], |wide[XW:0]};
    end
endmodule

// File: rtl/fp_norm_round.sv
`timescale 1ns/1ps
module fp_norm_round #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  sign_i,
    input  logic [EXP_W-1:0]      exp_i,
    input  logic [FRAC_W+4:0]     sum_i,
    output logic [EXP_W+FRAC_W:0] res_o,
    output logic                  ovf_o,
    output logic                  unf_o
);
    localparam int XW   = FRAC_W + 4;
    localparam int EMAX = (1 << EXP_W) - 2;

    int                 lead, sh, e;
    logic [XW-2:0]      nrm;
    logic               grd, rbit, stk, up;
    logic [FRAC_W:0]    inc;

    always_comb begin
        lead = 0;
        for (int i = 0; i <= XW; i++)
            if (sum_i[i]) lead = i;
        sh = 0;
        if (lead == XW) begin
            nrm = {sum_i[XW-1:2], sum_i[1] | sum_i[0]};
            e   = int'(exp_i) + 1;
        end else begin
            sh  = XW - 1 - lead;
            nrm = (XW-1)'(sum_i[XW-2:0] << sh);
            e   = int'(exp_i) - sh;
        end
        grd  = nrm[2];
        rbit = nrm[1];
        stk  = nrm[0];
        up   = grd & (rbit | stk | nrm[3]);
        inc  = {1'b0, nrm[XW-2:3]} + {{FRAC_W{1'b0}}, up};
        if (inc[FRAC_W]) e = e + 1;

        ovf_o = 1'b0;
        unf_o = 1'b0;
        if (sum_i == '0) begin
            res_o = '0;
        end else if (e > EMAX) begin
            res_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            ovf_o = 1'b1;
        end else if (e < 1) begin
            res_o = {sign_i, {(EXP_W+FRAC_W){1'b0}}};
            unf_o = 1'b1;
        end else begin
            res_o = {sign_i, EXP_W'(e), inc[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/fp_addsub.sv
`timescale 1ns/1ps
module fp_addsub #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  logic                  sub_sel,
    output logic [EXP_W+FRAC_W:0] res,
    output logic                  ovf,
    output logic                  unf
);
    import fp_pkg::*;

    localparam int WW = EXP_W + FRAC_W + 1;
    localparam int XW = FRAC_W + 4;
    localparam logic [WW-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic [WW-1:0] res;
        logic          ovf;
        logic          unf;
    } out_t;

    out_t out_d, out_q;

    logic             sa, sb, big_s, small_s;
    logic [EXP_W-1:0] ea, eb, big_e;
    logic [FRAC_W:0]  ma, mb;
    fp_cls_e          ca, cb;
    logic [XW-1:0]    big_x, small_x;
    logic [XW:0]      sum;
    logic [WW-1:0]    nr_res;
    logic             nr_ovf, nr_unf;

    fp_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
        .word_i(op_a), .flip_i(1'b0), .sign_o(sa), .exp_o(ea), .sig_o(ma), .cls_o(ca));
    fp_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
        .word_i(op_b), .flip_i(sub_sel), .sign_o(sb), .exp_o(eb), .sig_o(mb), .cls_o(cb));

    fp_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .sign_a_i(sa), .exp_a_i(ea), .sig_a_i(ma),
        .sign_b_i(sb), .exp_b_i(eb), .sig_b_i(mb),
        .big_sign_o(big_s), .small_sign_o(small_s), .big_exp_o(big_e),
        .big_ext_o(big_x), .small_ext_o(small_x));

    always_comb begin
        if (big_s ^ small_s)
            sum = {1'b0, big_x} - {1'b0, small_x};
        else
            sum = {1'b0, big_x} + {1'b0, small_x};
    end

    fp_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nr (
        .sign_i(big_s), .exp_i(big_e), .sum_i(sum),
        .res_o(nr_res), .ovf_o(nr_ovf), .unf_o(nr_unf));

    always_comb begin
        out_d = '0;
        if (ca == CLS_INF || cb == CLS_INF) begin
            if (ca == CLS_INF && cb == CLS_INF && sa != sb)
                out_d.res = QNAN;
            else
                out_d.res = {(ca == CLS_INF) ? sa : sb, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (ca == CLS_ZERO) begin
            if (cb == CLS_ZERO)
                out_d.res = {sb, {(EXP_W+FRAC_W){1'b0}}};
            else
                out_d.res = {sb, eb, mb[FRAC_W-1:0]};
        end else if (cb == CLS_ZERO) begin
            out_d.res = op_a;
        end else begin
            out_d.res = nr_res;
            out_d.ovf = nr_ovf;
            out_d.unf = nr_unf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign res = out_q.res;
    assign ovf = out_q.ovf;
    assign unf = out_q.unf;
endmodule

// File: rtl/fp_addsub_chk.sv
`timescale 1ns/1ps
module fp_addsub_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [EXP_W+FRAC_W:0] op_a,
    input logic [EXP_W+FRAC_W:0] op_b,
    input logic                  sub_sel,
    input logic [EXP_W+FRAC_W:0] res,
    input logic                  ovf,
    input logic                  unf
);
    localparam int MSB = EXP_W + FRAC_W;
    localparam logic [MSB:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [EXP_W-1:0] xa, xb;
    logic [MSB:0]     b_eff;
    logic             a_norm, b_norm;

    assign xa     = op_a[FRAC_W +: EXP_W];
    assign xb     = op_b[FRAC_W +: EXP_W];
    assign b_eff  = {op_b[MSB] ^ sub_sel, op_b[MSB-1:0]};
    assign a_norm = (xa != '0) && (xa != '1);
    assign b_norm = (xb != '0) && (xb != '1);

    assert_ovf_inf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (res[MSB-1:FRAC_W] == '1) && (res[FRAC_W-1:0] == '0));

    assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf));

    assert_unf_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unf |-> (res[MSB-1:0] == '0));

    assert_nan_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (res == QNAN) |-> ($past(xa) == '1) && ($past(xb) == '1));

    assert_zero_a_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xa == '0 && b_norm) |=> (res == $past(b_eff)) && !ovf && !unf);

    assert_cancel_pos_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_norm && op_a == {~b_eff[MSB], b_eff[MSB-1:0]}) |=> (res == '0) && !ovf && !unf);
endmodule

bind fp_addsub fp_addsub_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sub_sel(sub_sel),
    .res(res), .ovf(ovf), .unf(unf));

// File: tb/test_fp_addsub.sv
`timescale 1ns/1ps
module test_fp_addsub;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [31:0] a32 = '0, b32 = '0, r32;
    logic        s32 = 1'b0, o32, u32;
    logic [6:0]  a7 = '0, b7 = '0, r7;
    logic        s7 = 1'b0, o7, u7;

    int n_chk = 0;
    int n_bad = 0;

    fp_addsub i_fp_addsub (
        .clk(clk), .rst_n(rst_n), .op_a(a32), .op_b(b32), .sub_sel(s32),
        .res(r32), .ovf(o32), .unf(u32));

    fp_addsub #(.EXP_W(3), .FRAC_W(3)) i_small (
        .clk(clk), .rst_n(rst_n), .op_a(a7), .op_b(b7), .sub_sel(s7),
        .res(r7), .ovf(o7), .unf(u7));

    // Exact model of the 3/3 format: {res, ovf, unf}
    function automatic logic [8:0] model7(input logic [6:0] a, input logic [6:0] b, input logic sub);
        logic sa, sb, s;
        int ea, eb, va, vb, n, m, p, q, sh, rem, half, e;
        sa = a[6]; sb = b[6] ^ sub;
        ea = int'(a[5:3]); eb = int'(b[5:3]);
        if (ea == 7 || eb == 7) begin
            if (ea == 7 && eb == 7 && sa != sb) return {7'h3C, 2'b00};
            s = (ea == 7) ? sa : sb;
            return {s, 6'b111000, 2'b00};
        end
        if (ea == 0) begin
            if (eb == 0) return {sb, 6'b0, 2'b00};
            return {sb, b[5:0], 2'b00};
        end
        if (eb == 0) return {a, 2'b00};
        va = (8 + int'(a[2:0])) << (ea - 1);
        vb = (8 + int'(b[2:0])) << (eb - 1);
        if (sa) va = -va;
        if (sb) vb = -vb;
        n = va + vb;
        if (n == 0) return 9'b0;
        s = (n < 0);
        m = s ? -n : n;
        p = 0;
        for (int i = 0; i < 16; i++) if (m >= (1 << i)) p = i;
        e = p - 2;
        if (p <= 3) q = m << (3 - p);
        else begin
            sh = p - 3;
            q = m >> sh;
            rem = m & ((1 << sh) - 1);
            half = 1 << (sh - 1);
            if (rem > half || (rem == half && (q & 1) == 1)) q = q + 1;
            if (q == 16) begin q = 8; e = e + 1; end
        end
        if (e > 6) return {s, 6'b111000, 2'b10};
        if (e < 1) return {s, 6'b000000, 2'b01};
        return {s, 3'(e), 3'(q), 2'b00};
    endfunction

    function automatic string tag7(input logic [6:0] a, input logic [6:0] b, input logic [8:0] x);
        if (x[8:2] == 7'h3C) return "R11";
        if (a[5:3] == 3'd7 || b[5:3] == 3'd7) return "R10";
        if (a[5:3] == 3'd0 || b[5:3] == 3'd0) return "R3";
        if (x[1]) return "R7";
        if (x[0]) return "R8";
        if (x[8:2] == 7'h00) return "R9";
        return "R1/R2/R4/R5/R6";
    endfunction

    task automatic chk32(input logic [31:0] a, input logic [31:0] b, input logic sub,
                         input logic [31:0] er, input logic eo, input logic eu, input string tg);
        @(negedge clk);
        a32 = a; b32 = b; s32 = sub;
        @(posedge clk);
        #2;
        n_chk++;
        if (r32 !== er || o32 !== eo || u32 !== eu) begin
            n_bad++;
            $display("FAIL %s: %h %s %h got res=%h ovf=%b unf=%b expected res=%h ovf=%b unf=%b",
                     tg, a, sub ? "-" : "+", b, r32, o32, u32, er, eo, eu);
        end
    endtask

    initial begin
        #3000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [8:0] ex;
        a32 = 32'h3F800000; b32 = 32'h3F800000; a7 = 7'h1A; b7 = 7'h1A;
        repeat (3) @(posedge clk);
        #2;
        n_chk++;   // R12 reset state
        if (r32 !== 32'h0 || o32 !== 1'b0 || u32 !== 1'b0 || r7 !== 7'h0) begin
            n_bad++;
            $display("FAIL R12: reset got res=%h/%h ovf=%b unf=%b expected 0", r32, r7, o32, u32);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R12: output holds until the next rising edge
        chk32(32'h3F800000, 32'h40000000, 1'b0, 32'h40400000, 1'b0, 1'b0, "R1");
        @(negedge clk);
        a32 = 32'h40000000; b32 = 32'h40000000;
        #1;
        n_chk++;
        if (r32 !== 32'h40400000) begin
            n_bad++;
            $display("FAIL R12: mid-cycle got %h expected 40400000", r32);
        end

        chk32(32'h3F000000, 32'h3EE00000, 1'b1, 32'h3D800000, 1'b0, 1'b0, "R5");
        chk32(32'h40A00000, 32'hC0A00000, 1'b1, 32'h41200000, 1'b0, 1'b0, "R2");
        chk32(32'h40A00000, 32'h40A00000, 1'b1, 32'h00000000, 1'b0, 1'b0, "R9");
        chk32(32'hC0490FDB, 32'h40490FDB, 1'b0, 32'h00000000, 1'b0, 1'b0, "R9");
        chk32(32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, "R6");
        chk32(32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0, 1'b0, "R6");
        chk32(32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001, 1'b0, 1'b0, "R6");
        chk32(32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 1'b0, 1'b0, "R6");
        chk32(32'h3F800000, 32'h00800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, "R4");
        chk32(32'h3F800000, 32'h00800000, 1'b1, 32'h3F800000, 1'b0, 1'b0, "R4");
        chk32(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1'b1, 1'b0, "R7");
        chk32(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000, 1'b1, 1'b0, "R7");
        chk32(32'h00800001, 32'h00800000, 1'b1, 32'h00000000, 1'b0, 1'b1, "R8");
        chk32(32'h00800000, 32'h00800001, 1'b1, 32'h80000000, 1'b0, 1'b1, "R8");
        chk32(32'h00000000, 32'hC0B80000, 1'b0, 32'hC0B80000, 1'b0, 1'b0, "R3");
        chk32(32'h80000000, 32'h3F800000, 1'b1, 32'hBF800000, 1'b0, 1'b0, "R3");
        chk32(32'h40B80000, 32'h00000123, 1'b0, 32'h40B80000, 1'b0, 1'b0, "R3");
        chk32(32'h00000001, 32'h80000000, 1'b1, 32'h00000000, 1'b0, 1'b0, "R3");
        chk32(32'h80000001, 32'h80000000, 1'b0, 32'h80000000, 1'b0, 1'b0, "R3");
        chk32(32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, 1'b0, 1'b0, "R10");
        chk32(32'h7F800001, 32'h3F800000, 1'b0, 32'h7F800000, 1'b0, 1'b0, "R10");
        chk32(32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 1'b0, 1'b0, "R10");
        chk32(32'h7F800000, 32'h7F800000, 1'b0, 32'h7F800000, 1'b0, 1'b0, "R10");
        chk32(32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, 1'b0, 1'b0, "R11");
        chk32(32'hFF800000, 32'h7FC00000, 1'b0, 32'h7FC00000, 1'b0, 1'b0, "R11");

        // Exhaustive sweep of the 3-bit exponent / 3-bit fraction build
        for (int k = 0; k < 32768; k++) begin
            @(negedge clk);
            a7 = k[13:7]; b7 = k[6:0]; s7 = k[14];
            ex = model7(k[13:7], k[6:0], k[14]);
            @(posedge clk);
            #2;
            n_chk++;
            if ({r7, o7, u7} !== ex) begin
                n_bad++;
                $display("FAIL %s: %h %s %h got res=%h ovf=%b unf=%b expected res=%h ovf=%b unf=%b",
                         tag7(a7, b7, ex), a7, s7 ? "-" : "+", b7, r7, o7, u7, ex[8:2], ex[1], ex[0]);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule